// File: doc/BRIEF.md
# Mode-Register SPI Master

This block is a single-word SPI master that a host drives through a small register port. One configuration register sets everything about the serial link: whether the engine runs, whether it acts as master, internal loopback, the clock's resting level, which clock edge launches data, which end of the word leaves first, the word size and a two-stage clock divider. A word written to the transmit register moves into the shift engine as soon as the engine is idle. The engine then clocks it out on MOSI while it assembles the incoming bits from MISO. The received word lands right-justified in the receive register.

Two event flags report progress: receive-full and transmit-free. Each flag clears when 1 is written to it, and a mask register selects which flags raise the interrupt. The serial clock is derived from the block clock. Each half-period of SCK lasts 2×(P+1) block clocks, where P is the 4-bit prescale field, and an optional divide-by-16 stage stretches that by a further factor of 16.

Top module: `spi_mode_master`

## Requirements
- R1: After reset, the config, event and mask registers read 0, `irq` is 0, `sck` is 0 and `mosi` is 0.
- R2: The config field at bits 23:20 sets the word size. A value L from 3 to 15 gives L+1 bits, and 0 gives 32 bits. Every transfer produces exactly two SCK edges per bit.
- R3: Config bit 26 picks the bit order: 1 sends and receives the most significant bit first, and 0 sends the least significant bit first. The transmitted word is taken from the low bits of the transmit register.
- R4: Config bit 29 is the resting level of SCK. When config bit 28 is 0, the first bit is on MOSI before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. When bit 28 is 1, MOSI changes on leading edges after the first one, and MISO is sampled on trailing edges.
- R5: Each SCK half-period lasts 2×(P+1) clocks, where P is config bits 19:16. When config bit 27 is set, it lasts 32×(P+1) clocks.
- R6: When a word completes, it appears right-justified in the receive register (address 4), and event bit 9 is set. A read of the receive register with `reg_rd` high clears bit 9.
- R7: A write to the transmit register (address 3) clears event bit 8. Bit 8 is set again when the word enters the shift engine. That happens only while config bits 24 (run) and 25 (master) are both 1 and no word is shifting.
- R8: The register addresses are: config 0, event 1, mask 2. Writing 1 to an event bit clears that bit, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some event bit is 1 and the mask bit at the same position (bit 9 or bit 8) is also 1.
- R10: While config bit 30 is set, the receive side takes the bits being sent, MISO is ignored, and MOSI stays 0.
- R11: Clearing config bit 24 during a transfer stops it. SCK returns to its resting level within two clock edges, and no receive event follows.
- R12: While config bit 25 is 0, no transfer starts: SCK stays at rest and event bit 8 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe; a read of the receive register clears the receive flag |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked event interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A slave model in the bench shifts its own word back while it captures MOSI. It is swept over both clock levels, both launch edges and both bit orders at word sizes of 4, 5, 8, 16 and 32 bits. Those sweeps separate errors in edge choice (the slave would capture a shifted word), in bit order (the word would come back mirrored) and in length decoding (the edge count would be wrong). Loopback runs send a word that differs from the slave's, so a receive path that still listens to MISO is caught. Timing runs at three prescale settings measure the gap between edges to check the divider and its divide-by-16 stage.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam int REG_W   = 32;
  localparam int PM_W    = 4;
  localparam int LEN_W   = 4;
  localparam int D16_LOG = 4;
  localparam int EV_NF   = 8;
  localparam int EV_NE   = 9;
  localparam int CFG_LO  = 16;
  localparam int CFG_HI  = 30;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_EVT  = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_TX   = 3'd3;
  localparam logic [2:0] A_RX   = 3'd4;

  // field order follows config bits 30 down to 16
  typedef struct packed {
    logic             loop_en;
    logic             cpol;
    logic             cpha;
    logic             div16;
    logic             msb_first;
    logic             master;
    logic             run;
    logic [LEN_W-1:0] len;
    logic [PM_W-1:0]  pm;
  } cfg_t;
endpackage

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int PM_W    = 4,
  parameter int D16_LOG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [PM_W-1:0] pm,
  input  logic            div16,
  output logic            tick
);
  localparam int CNT_W = PM_W + D16_LOG + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, base, half;

  always_comb begin
    base = CNT_W'(pm) + CNT_W'(1);
    half = div16 ? (base << (D16_LOG + 1)) : (base << 1);
    tick = active && (cnt_q == half - CNT_W'(1));
    if (!active || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int W     = 32,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             msb_first,
  input  logic             loop_en,
  input  logic [LEN_W-1:0] len,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word,
  output logic             sck,
  output logic             mosi
);
  localparam int KW = $clog2(2 * W);
  localparam int NW = $clog2(W) + 1;
  localparam int IW = $clog2(W);

  logic          busy_q, busy_d, sck_q, sck_d;
  logic [KW-1:0] k_q, k_d;
  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d, rx_ins, rx_nx;
  logic [NW-1:0] nbits;
  logic [NW:0]   twice;
  logic [IW-1:0] top_idx;
  logic          last, lead, out_bit, rx_in, samp, shft;

  always_comb begin
    nbits   = (len == '0) ? NW'(W) : (NW'(len) + NW'(1));   // R2
    twice   = {nbits, 1'b0};
    top_idx = IW'(nbits - NW'(1));
    last    = (k_q == KW'(twice - (NW+1)'(1)));
    lead    = ~k_q[0];
    out_bit = msb_first ? tx_q[top_idx] : tx_q[0];           // R3
    rx_in   = loop_en ? out_bit : miso;                      // R10
    samp    = tick & (cpha ? ~lead : lead);                  // R4
    shft    = tick & (cpha ? (lead & (k_q != '0)) : (~lead & ~last));
    rx_ins  = msb_first ? {rx_q[W-2:0], rx_in}
                        : ((rx_q >> 1) | (W'(rx_in) << top_idx));
    rx_nx   = samp ? rx_ins : rx_q;
  end

  always_comb begin
    busy_d = busy_q;
    k_d    = k_q;
    sck_d  = sck_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!run) begin                      // R11: abort, clock to rest
      busy_d = 1'b0;
      k_d    = '0;
      sck_d  = cpol;
    end else if (!busy_q) begin
      k_d   = '0;
      sck_d = cpol;
      if (start) begin
        busy_d = 1'b1;
        tx_d   = tx_word;
        rx_d   = '0;
      end
    end else if (tick) begin
      k_d   = k_q + KW'(1);
      sck_d = ~sck_q;
      rx_d  = rx_nx;
      if (shft) tx_d = msb_first ? (tx_q << 1) : (tx_q >> 1);
      if (last) begin
        busy_d = 1'b0;
        k_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      sck_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      k_q    <= k_d;
      sck_q  <= sck_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q & run & tick & last;
  assign rx_word = rx_nx;
  assign sck     = sck_q;
  assign mosi    = busy_q & ~loop_en & out_bit;
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  logic [1:0]       rs_q;
  logic             srst_n;
  cfg_t             cfg_q, cfg_d;
  logic [1:0]       evt_q, evt_d, msk_q, msk_d;   // [1]=receive full, [0]=transmit free
  logic [REG_W-1:0] txh_q, txh_d, rx_q, rx_d;
  logic             txf_q, txf_d;
  logic             cfg_we, evt_we, msk_we, tx_we, rd_rx;
  logic             run_w, load, tick, sh_busy, sh_done;
  logic [REG_W-1:0] sh_rx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  always_comb begin
    cfg_we = reg_wr && (reg_addr == A_CFG);
    evt_we = reg_wr && (reg_addr == A_EVT);
    msk_we = reg_wr && (reg_addr == A_MASK);
    tx_we  = reg_wr && (reg_addr == A_TX);
    rd_rx  = reg_rd && (reg_addr == A_RX);
    run_w  = cfg_q.run & cfg_q.master;                // R12
    load   = run_w & ~sh_busy & txf_q;                // R7
  end

  always_comb begin
    cfg_d = cfg_we ? cfg_t'(reg_wdata[CFG_HI:CFG_LO]) : cfg_q;
    msk_d = msk_we ? reg_wdata[EV_NE:EV_NF] : msk_q;
    txh_d = tx_we ? reg_wdata : txh_q;
    rx_d  = sh_done ? sh_rx : rx_q;                   // R6
    if (tx_we)     txf_d = 1'b1;
    else if (load) txf_d = 1'b0;
    else           txf_d = txf_q;
    evt_d = evt_q;
    if (sh_done)                                    evt_d[1] = 1'b1;
    else if (rd_rx || (evt_we && reg_wdata[EV_NE])) evt_d[1] = 1'b0;   // R6 R8
    if (tx_we)                                      evt_d[0] = 1'b0;   // R7
    else if (load)                                  evt_d[0] = 1'b1;
    else if (evt_we && reg_wdata[EV_NF])            evt_d[0] = 1'b0;   // R8
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q <= '0;
      evt_q <= '0;
      msk_q <= '0;
      txh_q <= '0;
      txf_q <= 1'b0;
      rx_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      evt_q <= evt_d;
      msk_q <= msk_d;
      txh_q <= txh_d;
      txf_q <= txf_d;
      rx_q  <= rx_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {1'b0, cfg_q, 16'h0000};
      A_EVT:   reg_rdata = REG_W'(evt_q) << EV_NF;
      A_MASK:  reg_rdata = REG_W'(msk_q) << EV_NF;
      A_RX:    reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(evt_q & msk_q);                      // R9

  spi_baud_div #(.PM_W(PM_W), .D16_LOG(D16_LOG)) u_div (
    .clk(clk), .rst_n(srst_n), .active(sh_busy),
    .pm(cfg_q.pm), .div16(cfg_q.div16), .tick(tick)
  );

  spi_shift_eng #(.W(REG_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(srst_n), .run(run_w), .start(load), .tick(tick),
    .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .msb_first(cfg_q.msb_first),
    .loop_en(cfg_q.loop_en), .len(cfg_q.len), .tx_word(txh_q), .miso(miso),
    .busy(sh_busy), .done(sh_done), .rx_word(sh_rx), .sck(sck), .mosi(mosi)
  );
endmodule

// File: rtl/spi_mode_master_chk.sv
module spi_mode_master_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       run_w,
  input logic       cpol,
  input logic       loop_en,
  input logic       sh_busy,
  input logic       sh_done,
  input logic       sck,
  input logic       mosi,
  input logic       irq,
  input logic [1:0] evt_q,
  input logic [1:0] msk_q,
  input logic       rd_rx
);
  AST_SCK_REST_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!srst_n)
    !run_w |=> (sck == $past(cpol)));                          // R11
  AST_NO_SHIFT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!srst_n)
    !run_w |=> !sh_busy);                                      // R12
  AST_LOOP_QUIET_MOSI: assert property (@(posedge clk) disable iff (!srst_n)
    loop_en |-> !mosi);                                        // R10
  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!srst_n)
    (msk_q == 2'b00) |-> !irq);                                // R9
  AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!srst_n)
    sh_done |=> evt_q[1]);                                     // R6
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_rx && !sh_done) |=> !evt_q[1]);                        // R6
endmodule

bind spi_mode_master spi_mode_master_chk u_chk (
  .clk(clk), .srst_n(srst_n), .run_w(run_w), .cpol(cfg_q.cpol),
  .loop_en(cfg_q.loop_en), .sh_busy(sh_busy), .sh_done(sh_done),
  .sck(sck), .mosi(mosi), .irq(irq), .evt_q(evt_q), .msk_q(msk_q),
  .rd_rx(rd_rx)
);

// File: tb/sim_spi_mode_master.sv
`timescale 1ns/1ps
module sim_spi_mode_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, sck, mosi;
  logic        miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_mode_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] mask_sh = 32'd0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // slave model: config written by the task, state owned here
  logic        s_cpol = 0, s_cpha = 0, s_msb = 0, slv_on = 0;
  int          s_nb = 8;
  logic [31:0] s_word = 0;
  logic [31:0] capt = 0;
  int          edge_n = 0, idx = 0, t1 = 0, half_meas = 0;
  logic        sck_prev = 0, mosi_pre = 0;

  always @(posedge clk) mosi_pre <= mosi;

  function automatic logic bitsel(logic [31:0] w, int i, int nb, logic msb);
    if (i >= nb) return 1'b0;
    return msb ? w[nb-1-i] : w[i];
  endfunction

  always @(negedge clk) begin
    if (!slv_on) begin
      edge_n = 0; capt = 0; idx = 0;
      miso = bitsel(s_word, 0, s_nb, s_msb);
    end else if (sck !== sck_prev) begin
      edge_n = edge_n + 1;
      if (edge_n == 1) t1 = cyc;
      if (edge_n == 2) half_meas = cyc - t1;
      if ((s_cpha ? (sck == s_cpol) : (sck != s_cpol))) begin
        if (s_msb) capt = {capt[30:0], mosi_pre};
        else       capt = (capt >> 1) | (32'(mosi_pre) << (s_nb - 1));
      end else if (!(s_cpha && edge_n == 1)) begin
        idx = idx + 1;
        miso = bitsel(s_word, idx, s_nb, s_msb);
      end
    end
    sck_prev = sck;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic clr, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = clr;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk_cfg(bit lp, bit cp, bit ph, bit d16, bit msb,
                                         bit mst, bit en, int nb, int pm);
    logic [3:0] lf;
    lf = (nb == 32) ? 4'd0 : 4'(nb - 1);
    return {1'b0, lp, cp, ph, d16, msb, mst, en, lf, 4'(pm), 16'h0000};
  endfunction

  task automatic xfer(input string tag, input bit lp, input bit cp, input bit ph,
                      input bit msb, input int nb, input int pm, input bit d16,
                      input logic [31:0] tw, input logic [31:0] sw, input int exp_half);
    logic [31:0] d, nbm;
    int n;
    nbm = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
    s_cpol = cp; s_cpha = ph; s_msb = msb; s_nb = nb; s_word = sw;
    wr(3'd0, mk_cfg(lp, cp, ph, d16, msb, 1, 0, nb, pm));
    wr(3'd0, mk_cfg(lp, cp, ph, d16, msb, 1, 1, nb, pm));
    @(negedge clk);
    slv_on = 1'b1;
    wr(3'd3, tw);
    n = 0; d = 0;
    while (!d[9] && n < 40000) begin
      rd(3'd1, 1'b0, d);
      n = n + 1;
    end
    chk({tag, " R9 irq"}, 32'(irq), 32'(|(d[9:8] & mask_sh[9:8])));
    rd(3'd4, 1'b1, d);
    chk({tag, " R6 R2 R3 received word"}, d, (lp ? tw : sw) & nbm);
    if (lp) chk({tag, " R10 mosi quiet"}, capt, 32'd0);
    else    chk({tag, " R3 R4 slave capture"}, capt, tw & nbm);
    chk({tag, " R2 edge count"}, 32'(edge_n), 32'(2 * nb));
    chk({tag, " R4 sck at rest"}, 32'(sck), 32'(cp));
    rd(3'd1, 1'b0, d);
    chk({tag, " R6 flag cleared by read"}, 32'(d[9]), 32'd0);
    if (exp_half > 0) chk({tag, " R5 half period"}, 32'(half_meas), 32'(exp_half));
    slv_on = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    int lens[5];
    int k;
    lens = '{4, 5, 8, 16, 32};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, 0, d); chk("R1 config", d, 0);
    rd(3'd1, 0, d); chk("R1 event", d, 0);
    rd(3'd2, 0, d); chk("R1 mask", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sck", 32'(sck), 0);
    chk("R1 mosi", 32'(mosi), 0);

    // R8 R9 flag and mask behaviour after one transfer
    xfer("base", 0, 0, 0, 1, 8, 0, 0, 32'h0000_00A7, 32'h0000_003C, 2);
    rd(3'd1, 0, d); chk("R7 transmit-free set", d, 32'h100);
    wr(3'd2, 32'h100); mask_sh = 32'h100;
    rd(3'd2, 0, d); chk("R8 mask readback", d, 32'h100);
    chk("R9 irq raised", 32'(irq), 1);
    wr(3'd1, 32'h0);
    rd(3'd1, 0, d); chk("R8 write 0 keeps", d, 32'h100);
    wr(3'd1, 32'h100);
    rd(3'd1, 0, d); chk("R8 write 1 clears", d, 0);
    chk("R9 irq dropped", 32'(irq), 0);
    wr(3'd2, 32'h200); mask_sh = 32'h200;

    // R2 R3 R4 sweep of level, phase, order and size
    k = 0;
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int ms = 0; ms < 2; ms++)
          for (int li = 0; li < 5; li++) begin
            k = k + 1;
            xfer("sweep", 0, cp[0], ph[0], ms[0], lens[li], 0, 0,
                 32'hA5C3_96E1 ^ (32'(k) * 32'h1F3D_5B79),
                 32'h3C69_D24B ^ (32'(k) * 32'h7A11_0C35), 2);
          end

    // R10 loopback ignores MISO
    for (int ms = 0; ms < 2; ms++) begin
      xfer("loop", 1, 0, 0, ms[0], 13, 0, 0, 32'h0000_1B5D, 32'h0000_04A2, 0);
      xfer("loop", 1, 1, 1, ms[0], 32, 0, 0, 32'hC0FF_EE51, 32'h1234_5678, 0);
    end

    // R5 divider settings
    xfer("rate pm2", 0, 0, 0, 1, 8, 2, 0, 32'h0000_0096, 32'h0000_0069, 6);
    xfer("rate d16", 0, 1, 0, 0, 4, 0, 1, 32'h0000_000B, 32'h0000_0006, 32);
    xfer("rate max", 0, 0, 1, 1, 4, 15, 1, 32'h0000_0009, 32'h0000_0005, 512);

    // R11 abort mid-word
    wr(3'd1, 32'h300);
    wr(3'd0, mk_cfg(0, 1, 0, 0, 1, 1, 0, 32, 3));
    wr(3'd0, mk_cfg(0, 1, 0, 0, 1, 1, 1, 32, 3));
    wr(3'd3, 32'hFFFF_0000);
    repeat (37) @(negedge clk);
    wr(3'd0, mk_cfg(0, 1, 0, 0, 1, 1, 0, 32, 3));
    @(negedge clk);
    chk("R11 sck back at rest", 32'(sck), 1);
    repeat (300) @(negedge clk);
    chk("R11 sck stays at rest", 32'(sck), 1);
    rd(3'd1, 0, d); chk("R11 no receive event", d, 32'h100);

    // R12 master bit clear: nothing starts; R7 start once set
    wr(3'd1, 32'h300);
    wr(3'd0, mk_cfg(0, 0, 0, 0, 1, 0, 1, 8, 0));
    wr(3'd3, 32'h0000_0055);
    repeat (100) @(negedge clk);
    chk("R12 sck idle", 32'(sck), 0);
    rd(3'd1, 0, d); chk("R12 word not taken", d, 0);
    wr(3'd0, mk_cfg(0, 0, 0, 0, 1, 1, 1, 8, 0));
    repeat (3) @(negedge clk);
    rd(3'd1, 0, d); chk("R7 word taken when master", d & 32'h100, 32'h100);
    wr(3'd0, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule